// File: doc/BRIEF.md
# ACPI Wake and Firmware Event Router

This block collects power-management events and turns them into two interrupt request levels: a system control interrupt (SCI) request and a system management interrupt (SMI) request. Events come from three sources. Three asynchronous wake inputs are each resynchronised, and a rising edge on one of them is one event. Firmware can write a release strobe that sets a global-lock status bit. Software can write a global-release strobe that raises an SMI when firmware has permitted it. Each event sets a sticky status bit that software clears by writing 1 to it.

Every event is latched whatever the enable settings are, so software can poll status with interrupts turned off. A wake input can drive the SCI only when it is configured as an input, its own enable is set, the global SCI enable is set and its SMI-override bit is clear. When the SMI-override bit of an input is set, that input's events are recorded in the SMI status register instead of the wake status field, and they raise the SMI.

Software reaches the block through a word-addressed register bus. The bus has a 3-bit word address, 16-bit write data, a write strobe, two byte-lane enables and combinational read data.

Top module: `acpi_evt_router`

## Requirements
- R1: Word 0 (event status) holds the wake status of input i at bit 8+i and the global-lock status at bit 0. All other bits of word 0, including bits 15:12, read 0.
- R2: A rising edge on wake_in[i] sets its status three clock edges after the input changes (two synchroniser flops, then an edge detector). A held-high input produces exactly one event. Status stays set until software clears it.
- R3: A write to word 0 with byte_en[1]=1 clears each wake status bit whose data bit is 1. Data bits of 0 leave the status unchanged. With byte_en[0]=1, bit 0 clears the global-lock status in the same way.
- R4: Status is set even when every enable, including the global SCI enable, is 0.
- R5: The wake status of input i drives sci_o only when all of the following hold: direction bit i is 0, enable bit 8+i of word 1 is 1, the global SCI enable is 1 and override bit i is 0. The direction bits are word 3 bits 2:0, the override bits are word 3 bits 6:4 and the global SCI enable is word 3 bit 8.
- R6: When override bit i is 1, an edge on wake_in[i] sets SMI status bit 0 (word 4) and leaves the wake status unchanged. smi_o then rises and sci_o is not asserted by that edge.
- R7: Writing 1 to bit 1 of word 2 (the firmware-release strobe) sets the global-lock status. That bit always reads 0. The global-lock status drives sci_o when the global-lock enable (word 1 bit 0) is 1, independent of the global SCI enable.
- R8: Writing 1 to bit 0 of word 5 (the global-release strobe) sets SMI status bit 1 only when the firmware-enable bit (word 2 bit 0) is 1. When that bit is 0, the write has no effect. Word 5 reads 0.
- R9: Word 2 resets to 0x0000. Its bits 7:2 read 0 even after they are written with 1.
- R10: If a wake event and a write-1-to-clear of the same status bit fall in the same cycle, the bit ends up set.
- R11: sci_o stays asserted until the contributing status is cleared. smi_o is 1 exactly while any SMI status bit (word 4 bits 1:0) is set, and those bits are cleared by writing 1.
- R12: A write changes only the bytes whose byte_en bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register word address |
| wdata | input | 16 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| byte_en | input | 2 | Byte-lane enables for writes |
| rdata | output | 16 | Read data for the word at addr (combinational) |
| wake_in | input | 3 | Asynchronous wake inputs |
| sci_o | output | 1 | SCI request level |
| smi_o | output | 1 | SMI request level |

## Verification
The bench sweeps every combination of direction, enable, global SCI enable and override for each wake input, and computes the expected sci_o, smi_o and status from the gating rule. A design that gated the SCI on the wrong condition, or let an override leak into the SCI path, fails that sweep. A design that latched status only when enabled fails too. A cleared write timed into the exact cycle of an edge detect catches a design where the clear beats the set, which would lose the event. Other checks target the reserved and write-only bits reading back as 1, a global-release write passing while firmware-enable is 0, and writes ignoring byte_en. In each of those, a faulty design shows the wrong read value or an SMI request with no cause.

// File: rtl/acpi_evt_router.sv
module acpi_evt_router #(
  parameter int NWAKE = 3,
  parameter int DW = 16,
  parameter int AW = 3,
  parameter int WAKE_LSB = 8,
  parameter int OVR_LSB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          wr_en,
  input  logic [1:0]    byte_en,
  output logic [DW-1:0] rdata,
  input  logic [NWAKE-1:0] wake_in,
  output logic          sci_o,
  output logic          smi_o
);
  localparam logic [AW-1:0] A_STS = 0, A_EN = 1, A_CTL = 2, A_CFG = 3, A_SMI = 4, A_REL = 5;
  localparam int SCI_EN_BIT = 8;

  logic [NWAKE-1:0] s1, s2, prev;
  logic [NWAKE-1:0] wake_sts, wake_en, dir, ovr;
  logic gbl_sts, gbl_en, fw_en, sci_glb_en;
  logic [1:0] smi_sts;

  logic unused_bits;
  assign unused_bits = ^wdata;

  wire wr_lo = wr_en && byte_en[0];
  wire wr_hi = wr_en && byte_en[1];

  wire [NWAKE-1:0] edge_det = s2 & ~prev;
  wire [NWAKE-1:0] wake_set = edge_det & ~ovr;
  wire smi_wake_set = |(edge_det & ovr);
  wire [NWAKE-1:0] wake_clr = (wr_hi && addr == A_STS) ? wdata[WAKE_LSB +: NWAKE] : '0;
  wire gbl_set = wr_lo && addr == A_CTL && wdata[1];
  wire gbl_clr = wr_lo && addr == A_STS && wdata[0];
  wire rel_set = wr_lo && addr == A_REL && wdata[0] && fw_en;
  wire [1:0] smi_clr = (wr_lo && addr == A_SMI) ? wdata[1:0] : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      prev <= '0;
    end else begin
      s1 <= wake_in;
      s2 <= s1;
      prev <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_sts <= '0;
      gbl_sts <= 1'b0;
      smi_sts <= 2'b00;
    end else begin
      wake_sts <= (wake_sts & ~wake_clr) | wake_set;
      gbl_sts <= (gbl_sts & ~gbl_clr) | gbl_set;
      smi_sts <= (smi_sts & ~smi_clr) | {rel_set, smi_wake_set};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_en <= '0;
      gbl_en <= 1'b0;
      fw_en <= 1'b0;
      dir <= '0;
      ovr <= '0;
      sci_glb_en <= 1'b0;
    end else begin
      if (wr_lo && addr == A_EN) gbl_en <= wdata[0];
      if (wr_hi && addr == A_EN) wake_en <= wdata[WAKE_LSB +: NWAKE];
      if (wr_lo && addr == A_CTL) fw_en <= wdata[0];
      if (wr_lo && addr == A_CFG) begin
        dir <= wdata[NWAKE-1:0];
        ovr <= wdata[OVR_LSB +: NWAKE];
      end
      if (wr_hi && addr == A_CFG) sci_glb_en <= wdata[SCI_EN_BIT];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_STS: begin
        rdata[0] = gbl_sts;
        rdata[WAKE_LSB +: NWAKE] = wake_sts;
      end
      A_EN: begin
        rdata[0] = gbl_en;
        rdata[WAKE_LSB +: NWAKE] = wake_en;
      end
      A_CTL: rdata[0] = fw_en;
      A_CFG: begin
        rdata[NWAKE-1:0] = dir;
        rdata[OVR_LSB +: NWAKE] = ovr;
        rdata[SCI_EN_BIT] = sci_glb_en;
      end
      A_SMI: rdata[1:0] = smi_sts;
      default: rdata = '0;
    endcase
  end

  assign sci_o = (sci_glb_en && |(wake_sts & wake_en & ~dir & ~ovr)) || (gbl_sts && gbl_en);
  assign smi_o = |smi_sts;

  AST_SCI_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    sci_o |-> (sci_glb_en || (gbl_sts && gbl_en))); // R5
  AST_REL_SETS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && byte_en[0] && addr == A_CTL && wdata[1]) |=> gbl_sts); // R7
  AST_RELEASE_NEEDS_FW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smi_sts[1]) |-> $past(fw_en)); // R8
  AST_CTL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_CTL) |-> (rdata[DW-1:1] == '0)); // R9
  AST_SMI_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    smi_o |-> (smi_sts != 2'b00)); // R11

  for (genvar g = 0; g < NWAKE; g++) begin : g_chk
    AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_sts[g] && !(wr_en && byte_en[1] && addr == A_STS && wdata[WAKE_LSB+g])) |=> wake_sts[g]); // R2
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_det[g] && !ovr[g]) |=> wake_sts[g]); // R10
    AST_OVR_TO_SMI: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_det[g] && ovr[g]) |=> smi_sts[0]); // R6
  end
endmodule

// File: tb/tb_acpi_evt_router.sv
module tb_acpi_evt_router;
  logic clk = 0, rst_n = 0;
  logic [2:0] addr = '0;
  logic [15:0] wdata = '0;
  logic wr_en = 0;
  logic [1:0] byte_en = '0;
  logic [15:0] rdata;
  logic [2:0] wake_in = '0;
  logic sci_o, smi_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  acpi_evt_router dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .byte_en(byte_en), .rdata(rdata), .wake_in(wake_in), .sci_o(sci_o), .smi_o(smi_o));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    addr = a; wdata = d; byte_en = be; wr_en = 1;
    @(negedge clk);
    wr_en = 0; byte_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse(input int i);
    @(negedge clk); wake_in[i] = 1;
    repeat (4) @(negedge clk);
    wake_in[i] = 0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(2, d); chk("R9 ctl reset", d, 16'h0000);
    rd(0, d); chk("R1 sts reset", d, 16'h0000);
    chk("R11 reset levels", {14'b0, sci_o, smi_o}, 16'h0);

    wr(2, 16'hFFFD, 2'b11);
    rd(2, d); chk("R9 rsvd reads zero", d, 16'h0001);
    wr(2, 16'h0000, 2'b01);

    for (int i = 0; i < 3; i++) begin
      for (int c = 0; c < 16; c++) begin
        logic dr, en, ge, ov, exp_sci;
        dr = c[0]; en = c[1]; ge = c[2]; ov = c[3];
        wr(3, 16'((ov << (4 + i)) | (dr << i) | (ge << 8)), 2'b11);
        wr(1, 16'(en << (8 + i)), 2'b11);
        pulse(i);
        exp_sci = !dr && en && ge && !ov;
        rd(0, d); chk("R1 R4 R6 wake status", d, ov ? 16'h0 : 16'(1 << (8 + i)));
        rd(4, d); chk("R6 smi status", d, {15'b0, ov});
        chk("R5 sci gating", {15'b0, sci_o}, {15'b0, exp_sci});
        chk("R6 smi level", {15'b0, smi_o}, {15'b0, ov});
        wr(0, 16'h0700, 2'b10);
        wr(4, 16'h0003, 2'b01);
        chk("R3 R11 cleared", {14'b0, sci_o, smi_o}, 16'h0);
      end
    end

    wr(3, 16'h0100, 2'b11);
    wr(1, 16'h0700, 2'b11);
    @(negedge clk); wake_in[1] = 1;
    repeat (10) @(negedge clk);
    rd(0, d); chk("R2 one event set", d, 16'h0200);
    wr(0, 16'h0200, 2'b10);
    repeat (6) @(negedge clk);
    rd(0, d); chk("R2 held input no new event", d, 16'h0000);
    wake_in[1] = 0;

    pulse(0);
    wr(0, 16'h0000, 2'b11);
    rd(0, d); chk("R3 write zero keeps", d, 16'h0100);
    chk("R11 sci held", {15'b0, sci_o}, 16'h1);
    wr(0, 16'h0100, 2'b01);
    rd(0, d); chk("R12 wrong lane no clear", d, 16'h0100);

    @(negedge clk); wake_in[2] = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    pulse(2);
    @(negedge clk); wake_in[2] = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); addr = 0; wdata = 16'h0400; byte_en = 2'b10; wr_en = 1;
    @(negedge clk); wr_en = 0; byte_en = 0;
    rd(0, d); chk("R10 set wins over clear", d[10], 1'b1);
    wake_in[2] = 0;
    wr(0, 16'h0701, 2'b11);
    repeat (4) @(negedge clk);

    wr(1, 16'h0000, 2'b11);
    wr(2, 16'h0002, 2'b01);
    rd(0, d); chk("R7 lock status", d, 16'h0001);
    rd(2, d); chk("R7 strobe reads zero", d, 16'h0000);
    chk("R7 no sci when lock disabled", {15'b0, sci_o}, 16'h0);
    wr(3, 16'h0000, 2'b11);
    wr(1, 16'h0001, 2'b01);
    chk("R7 sci from lock", {15'b0, sci_o}, 16'h1);
    wr(0, 16'h0001, 2'b01);
    chk("R3 lock cleared", {15'b0, sci_o}, 16'h0);

    wr(5, 16'h0001, 2'b01);
    rd(4, d); chk("R8 release ignored", d, 16'h0000);
    chk("R8 no smi", {15'b0, smi_o}, 16'h0);
    wr(2, 16'h0001, 2'b01);
    wr(5, 16'h0001, 2'b01);
    rd(4, d); chk("R8 release smi", d, 16'h0002);
    rd(5, d); chk("R8 reads zero", d, 16'h0000);
    chk("R11 smi level", {15'b0, smi_o}, 16'h1);
    wr(4, 16'h0002, 2'b01);
    chk("R11 smi cleared", {15'b0, smi_o}, 16'h0);

    wr(3, 16'hFFFF, 2'b01);
    rd(3, d); chk("R12 low lane only", d, 16'h0077);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule